// File: doc/BRIEF.md
# Parallel I/O Port Controller

This block gives a host processor twenty-four general-purpose I/O pins, grouped as two 8-bit ports (A and B) and a third 8-bit port (C) whose upper and lower nibbles are configured independently. The host reaches the block over an 8-bit data bus qualified by active-low select, read and write strobes and a 2-bit address. Only simple I/O is provided: each port, or each half of port C, is either a plain input that reflects its pins or a plain output that drives a latched value. There is no handshake and no interrupt.

Two register groups divide the pins. The first group covers port A and the upper half of port C, and the second covers port B and the lower half of port C. A direction command sets all four directions at once and clears every output latch. A second command form, sent to the same address, sets or clears a single port C bit without touching the others. The bus data path is split into an input, an output and an output-enable, so a bidirectional pad can be built at the chip edge. Each pin has its own output enable, so an external tri-state pad can be modelled.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset every pin enable is 0 (all ports input), every output latch is 0, and a read of the control address returns 0x9B.
- R2: `bus_dout_en` is 1 only in the cycle after a clock edge at which select and read are both low and write is high; otherwise it is 0 and `bus_dout` is 0.
- R3: A control write with bit 7 = 1 sets the directions: bit 4 for port A, bit 3 for port C bits 7..4, bit 1 for port B and bit 0 for port C bits 3..0, where 1 means input (pin enables 0) and 0 means output (pin enables 1).
- R4: A write to address 0 (A), 1 (B) or 2 (C) stores the data byte in that port's output latch, which drives the `*_out` pins until the latch is changed again.
- R5: A read of a port configured as input returns the pin values present at the read edge.
- R6: A read of port C returns, for each nibble, the latch when that nibble is an output and the pins when it is an input.
- R7: A control write with bit 7 = 0 loads bit 0 into the port C latch bit selected by bits 3..1, leaves the other port C bits unchanged and does not change the value read back from the control address.
- R8: A control write with bit 7 = 1 clears the A, B and C output latches to 0.
- R9: A write commits once, at the first clock edge of a select-and-write-low period; data changes while the strobe stays low, and strobes with select high, have no effect.
- R10: A read of port A or B configured as output returns its latch, not its pins; a read of the control address returns the last direction command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 2 | Register address: 0 A, 1 B, 2 C, 3 control |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host (registered) |
| bus_dout_en | output | 1 | Drive enable for the host data bus |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
The bound checker watches, on every cycle, that the bus drive enable appears only after a selected read, that each port and each port C nibble has uniform pin enables, that no latch or enable changes without a selected write, and that a direction command leaves all latches at zero. Only the bench scenarios can show the bit mapping of the direction command, the value mixing on port C reads, single-bit updates at chosen positions, read data for each address, and that a strobe held low commits just its first byte.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int BIT_IDX_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PA   = 2'd0,
    SEL_PB   = 2'd1,
    SEL_PC   = 2'd2,
    SEL_CTRL = 2'd3
  } port_sel_e;

  // control word field positions
  localparam int CW_KIND  = 7;
  localparam int CW_DIR_A = 4;
  localparam int CW_DIR_H = 3;
  localparam int CW_DIR_B = 1;
  localparam int CW_DIR_L = 0;
  localparam int CW_IDX_LO = 1;
  localparam int CW_VAL   = 0;

  // all groups input after reset
  localparam logic [DATA_W-1:0] CW_RESET = 8'h9B;

  typedef struct packed {
    logic in_a;
    logic in_b;
    logic in_chi;
    logic in_clo;
  } dir_cfg_t;

  function automatic dir_cfg_t decode_dirs(input logic [DATA_W-1:0] cw);
    dir_cfg_t d;
    d.in_a   = cw[CW_DIR_A];
    d.in_b   = cw[CW_DIR_B];
    d.in_chi = cw[CW_DIR_H];
    d.in_clo = cw[CW_DIR_L];
    return d;
  endfunction
endpackage

// File: rtl/ppio_bus_if.sv
module ppio_bus_if
  import ppio_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_pulse,
  output port_sel_e     sel,
  output logic [DW-1:0] wr_data,
  output logic          rd_act
);
  logic wr_act;
  logic wr_act_q;

  assign wr_act  = !cs_n && !wr_n;
  assign rd_act  = !cs_n && !rd_n && wr_n;
  assign sel     = port_sel_e'(addr);
  assign wr_data = din;

  always_ff @(posedge clk) begin
    if (rst) wr_act_q <= 1'b0;
    else     wr_act_q <= wr_act;
  end

  // one commit per strobe: only the first active edge counts
  assign wr_pulse = wr_act && !wr_act_q;
endmodule

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg
  import ppio_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = BIT_IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_pulse,
  input  port_sel_e     sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mode_q,
  output logic          mode_load,
  output logic          bit_en,
  output logic [IW-1:0] bit_idx,
  output logic          bit_val,
  output dir_cfg_t      dirs
);
  logic ctrl_wr;

  assign ctrl_wr   = wr_pulse && (sel == SEL_CTRL);
  assign mode_load = ctrl_wr && wr_data[CW_KIND];
  assign bit_en    = ctrl_wr && !wr_data[CW_KIND];
  assign bit_idx   = wr_data[CW_IDX_LO +: IW];
  assign bit_val   = wr_data[CW_VAL];

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= CW_RESET;
    else if (mode_load) mode_q <= wr_data;
  end

  assign dirs = decode_dirs(mode_q);
endmodule

// File: rtl/ppio_lane.sv
module ppio_lane #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic          is_in,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  rd_val
);
  localparam int OW = (W > 1) ? $clog2(W) : 1;
  localparam int HI = LO + W;
  localparam logic [IW-1:0] LO_V = IW'(LO);

  logic          hit;
  logic [IW-1:0] off;

  assign hit = bit_en && (int'(bit_idx) >= LO) && (int'(bit_idx) < HI);
  assign off = bit_idx - LO_V;

  always_ff @(posedge clk) begin
    if (rst)       latch_q <= '0;
    else if (clr)  latch_q <= '0;
    else if (load) latch_q <= load_data;
    else if (hit)  latch_q[off[OW-1:0]] <= bit_val;
  end

  assign oe     = {W{!is_in}};
  assign rd_val = is_in ? pin_in : latch_q;
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);

  logic          wr_pulse, rd_act;
  port_sel_e     sel;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] mode_q;
  logic          mode_load, bit_en, bit_val;
  logic [IW-1:0] bit_idx;
  dir_cfg_t      dirs;

  logic [DW-1:0] a_rd, b_rd;
  logic [HW-1:0] ch_rd, cl_rd;

  ppio_bus_if #(.DW(DW), .AW(AW)) u_bus (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .addr(bus_addr), .din(bus_din), .wr_pulse(wr_pulse), .sel(sel),
    .wr_data(wr_data), .rd_act(rd_act)
  );

  ppio_ctrl_reg #(.DW(DW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .sel(sel), .wr_data(wr_data),
    .mode_q(mode_q), .mode_load(mode_load), .bit_en(bit_en),
    .bit_idx(bit_idx), .bit_val(bit_val), .dirs(dirs)
  );

  ppio_lane #(.W(DW), .LO(0), .IW(IW)) u_lane_a (
    .clk(clk), .rst(rst), .clr(mode_load),
    .load(wr_pulse && sel == SEL_PA), .load_data(wr_data),
    .bit_en(1'b0), .bit_idx(bit_idx), .bit_val(bit_val),
    .is_in(dirs.in_a), .pin_in(pa_in),
    .latch_q(pa_out), .oe(pa_oe), .rd_val(a_rd)
  );

  ppio_lane #(.W(DW), .LO(0), .IW(IW)) u_lane_b (
    .clk(clk), .rst(rst), .clr(mode_load),
    .load(wr_pulse && sel == SEL_PB), .load_data(wr_data),
    .bit_en(1'b0), .bit_idx(bit_idx), .bit_val(bit_val),
    .is_in(dirs.in_b), .pin_in(pb_in),
    .latch_q(pb_out), .oe(pb_oe), .rd_val(b_rd)
  );

  // port C: two nibble lanes, each answering single-bit commands in its range
  ppio_lane #(.W(HW), .LO(HW), .IW(IW)) u_lane_ch (
    .clk(clk), .rst(rst), .clr(mode_load),
    .load(wr_pulse && sel == SEL_PC), .load_data(wr_data[DW-1:HW]),
    .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
    .is_in(dirs.in_chi), .pin_in(pc_in[DW-1:HW]),
    .latch_q(pc_out[DW-1:HW]), .oe(pc_oe[DW-1:HW]), .rd_val(ch_rd)
  );

  ppio_lane #(.W(HW), .LO(0), .IW(IW)) u_lane_cl (
    .clk(clk), .rst(rst), .clr(mode_load),
    .load(wr_pulse && sel == SEL_PC), .load_data(wr_data[HW-1:0]),
    .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
    .is_in(dirs.in_clo), .pin_in(pc_in[HW-1:0]),
    .latch_q(pc_out[HW-1:0]), .oe(pc_oe[HW-1:0]), .rd_val(cl_rd)
  );

  logic [DW-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_PA:   rd_mux = a_rd;
      SEL_PB:   rd_mux = b_rd;
      SEL_PC:   rd_mux = {ch_rd, cl_rd};
      default:  rd_mux = mode_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      bus_dout    <= rd_act ? rd_mux : '0;
      bus_dout_en <= rd_act;
    end
  end
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_din,
  input logic [DW-1:0] bus_dout,
  input logic          bus_dout_en,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] pc_oe
);
  localparam int HW = DW / 2;

  logic host_wr_q;
  always_ff @(posedge clk) begin
    if (rst) host_wr_q <= 1'b0;
    else     host_wr_q <= !bus_cs_n && !bus_wr_n;
  end

  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> $past(!bus_cs_n && !bus_rd_n && bus_wr_n)); // R2

  AST_QUIET_BUS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_dout_en |-> bus_dout == '0); // R2

  AST_GROUP_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ($countones(pa_oe) == 0 || $countones(pa_oe) == DW) &&
    ($countones(pb_oe) == 0 || $countones(pb_oe) == DW) &&
    ($countones(pc_oe[DW-1:HW]) == 0 || $countones(pc_oe[DW-1:HW]) == HW) &&
    ($countones(pc_oe[HW-1:0]) == 0 || $countones(pc_oe[HW-1:0]) == HW)); // R3

  AST_DIR_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !bus_wr_n && !host_wr_q && bus_addr == 2'd3 && bus_din[7])
    |=> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R8

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n || bus_wr_n) |=> ($stable(pa_out) && $stable(pb_out) &&
    $stable(pc_out) && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R9

  AST_HELD_STROBE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !bus_wr_n && host_wr_q) |=> ($stable(pa_out) &&
    $stable(pb_out) && $stable(pc_out) && $stable(pc_oe))); // R9
endmodule

bind ppio_ctrl ppio_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
  .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppio_ctrl_bench.sv
module ppio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  ppio_ctrl u_ppio_ctrl (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  // driver: pushes the expected read data, the monitor compares it
  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(req);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && dout_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=bus driven expected=idle bus");
      end else begin
        check(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
    check("R2 idle enable", {7'd0, dout_en}, 8'h00);
    bus_read(2'd3, 8'h9B, "R1 control readback");
    // R5 live inputs
    pa_in = 8'h5A;
    bus_read(2'd0, 8'h5A, "R5 port A pins");
    pa_in = 8'hC3;
    bus_read(2'd0, 8'hC3, "R5 port A pins changed");
    pb_in = 8'h66;
    bus_read(2'd1, 8'h66, "R5 port B pins");
    // R3 all outputs
    bus_write(2'd3, 8'h80);
    @(negedge clk);
    check("R3 pa_oe output", pa_oe, 8'hFF);
    check("R3 pb_oe output", pb_oe, 8'hFF);
    check("R3 pc_oe output", pc_oe, 8'hFF);
    bus_read(2'd3, 8'h80, "R10 control readback");
    // R4 / R10 output latch
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, 8'h3E);
    @(negedge clk);
    check("R4 pa_out", pa_out, 8'hA5);
    check("R4 pb_out", pb_out, 8'h3E);
    pa_in = 8'h11;
    bus_read(2'd0, 8'hA5, "R10 port A reads latch");
    bus_read(2'd1, 8'h3E, "R10 port B reads latch");
    // R9 deselected write and held strobe
    @(negedge clk);
    addr = 2'd0; din = 8'hFF; cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check("R9 deselected write ignored", pa_out, 8'hA5);
    addr = 2'd1; din = 8'h01; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    din = 8'h02;
    @(negedge clk);
    din = 8'h03;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    check("R9 held strobe commits once", pb_out, 8'h01);
    // R3 mixed directions, R8 clear: upper C input, lower C output, A out, B out
    bus_write(2'd3, 8'h88);
    @(negedge clk);
    check("R8 pa_out cleared", pa_out, 8'h00);
    check("R8 pb_out cleared", pb_out, 8'h00);
    check("R3 pc_oe nibbles", pc_oe, 8'h0F);
    // R6 port C mixed read
    bus_write(2'd2, 8'h3C);
    pc_in = 8'hB7;
    @(negedge clk);
    check("R4 pc_out", pc_out, 8'h3C);
    bus_read(2'd2, 8'hBC, "R6 port C mixed");
    // R7 single-bit commands
    bus_write(2'd3, 8'h0D);  // bit 6 set
    @(negedge clk);
    check("R7 set bit 6", pc_out, 8'h7C);
    bus_write(2'd3, 8'h04);  // bit 2 clear
    @(negedge clk);
    check("R7 clear bit 2", pc_out, 8'h78);
    bus_write(2'd3, 8'h01);  // bit 0 set
    @(negedge clk);
    check("R7 set bit 0", pc_out, 8'h79);
    check("R7 directions kept", pc_oe, 8'h0F);
    bus_read(2'd3, 8'h88, "R7 control readback unchanged");
    bus_read(2'd2, 8'hB9, "R6 port C after bit commands");
    // R3 port B input, R5
    bus_write(2'd3, 8'h92);
    @(negedge clk);
    check("R3 pa_oe input", pa_oe, 8'h00);
    check("R3 pb_oe input", pb_oe, 8'h00);
    check("R3 pc_oe all out", pc_oe, 8'hFF);
    check("R8 pc_out cleared", pc_out, 8'h00);
    pb_in = 8'h9D;
    bus_read(2'd1, 8'h9D, "R5 port B input");
    @(negedge clk);
    check("R2 enable released", {7'd0, dout_en}, 8'h00);
    check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule